// File: doc/BRIEF.md
# Synthesizer Serial Programming Front End

This block receives the three-wire programming stream of a frequency synthesizer. A word of `WORD_W` bits (21 by default) is clocked in serially on `ser_data` by `ser_clk`, most significant bit first. A rising edge on `ser_le` then transfers the word to one destination. The two bits shifted in last, C1 and then C2, pick that destination. The remaining leading bits become the payload that is stored.

The three serial pins are synchronized into the system clock domain. Every load event is handled in that domain. Three payload registers are kept: the reference divider word, the main divider word and the function word.

A one-cycle counter reset strobe is produced on an initialization load. The same strobe is produced on the first main-divider load that follows an initialization load. A level output asks the divider counters to stay at their load point and asks the charge pump to go to high impedance. A synchronous powerdown trigger is raised when the reset strobe coincides with the chip being enabled and the function word selecting synchronous powerdown.

Top module: `synth_prog_if`

## Requirements
- R1: Bits on `ser_data` are taken on each rising edge of `ser_clk`, most significant bit first. In a 21-bit word the first 19 bits form the payload (first bit = payload bit 18). The 20th bit is C1 and the 21st bit is C2.
- R2: On a rising edge of `ser_le` with {C1,C2} = 00, the payload is written to `r_word`. The other two words keep their values.
- R3: With {C1,C2} = 10, the payload is written to `n_word`.
- R4: With {C1,C2} = 01, the payload is written to `f_word` and no counter reset strobe is produced.
- R5: With {C1,C2} = 11, the payload is written to `f_word` as for code 01. In the same cycle `ctr_reset` is high for exactly one system clock cycle.
- R6: The first code-10 load after a code-11 load also produces the one-cycle `ctr_reset` strobe. Any later code-10 load produces no strobe until another code-11 load occurs.
- R7: `sync_pd` is high in exactly the cycle of a `ctr_reset` strobe when `chip_en` is high and `f_word` bits 1 and 17 are both set. For a code-11 load, the newly written value of `f_word` is the one that counts. In all other cycles `sync_pd` is low.
- R8: While `f_word` bit 0 is set, `hold_tristate` stays high and `sync_pd` is not raised by that bit alone.
- R9: `hold_tristate` is high during every `ctr_reset` strobe.
- R10: The stored words change only on a load. They hold their values while `chip_en` toggles, and loads are accepted while `chip_en` is low.
- R11: Reset clears all three words and the re-arm state. A code-10 load after reset gives no strobe.
- R12: The words and strobes update `SYNC_STAGES`+1 system clock cycles after `ser_le` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_le | input | 1 | Load-enable strobe |
| chip_en | input | 1 | Chip enable level |
| r_word | output | WORD_W-2 | Reference divider word |
| n_word | output | WORD_W-2 | Main divider word |
| f_word | output | WORD_W-2 | Function word |
| ctr_reset | output | 1 | One-cycle counter reset strobe |
| sync_pd | output | 1 | Synchronous powerdown trigger |
| hold_tristate | output | 1 | Hold counters at load point and tri-state the charge pump |

## Verification
Words are sent with different payload patterns:
- an alternating pattern, which would reveal a swapped or shifted bit;
- a pattern with only its first and last payload bits set, which checks the bit order;
- plain divider values.

All four destination codes are used. Loads are placed in sequences that tell the one-shot re-arm behaviour apart from a strobe on every main-divider load:
- an initialization load followed by two main-divider loads;
- a main-divider load after reset.

Powerdown is tried with the chip enabled and with it disabled. It is also tried with the level reset bit alone, with no initialization load, which separates the level hold from the strobe.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
   localparam int WORD_W_DEF = 21;
   localparam int CODE_W     = 2;
   // function word bit positions (payload-relative)
   localparam int FB_CRST    = 0;
   localparam int FB_PD_EN   = 1;
   localparam int FB_PD_SYNC = 17;

   typedef enum logic [CODE_W-1:0] {
      DST_REF  = 2'b00,
      DST_FUNC = 2'b01,
      DST_MAIN = 2'b10,
      DST_INIT = 2'b11
   } dest_e;
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
module sp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 0 && W >= 1) else $error("sp_sync: bad parameters");

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[i] <= '0;
               else        st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sp_shift.sv
`timescale 1ns/1ps
module sp_shift #(
   parameter int WORD_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdata,
   input  logic              le,
   output logic [WORD_W-1:0] word,
   output logic              le_rise
);
   initial assert (WORD_W >= 3) else $error("sp_shift: word too short");

   logic sclk_q, le_q;
   logic sclk_rise;

   assign sclk_rise = sclk & ~sclk_q;
   assign le_rise   = le & ~le_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
         word   <= '0;
      end else begin
         sclk_q <= sclk;
         le_q   <= le;
         if (sclk_rise) word <= {word[WORD_W-2:0], sdata};
      end
   end

   // R1: the register moves only on a serial clock rising edge
   p_shift_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(word));
   // R1: newest bit enters at the low end
   p_shift_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> word[0] == $past(sdata));
endmodule

// File: rtl/sp_latch_ctl.sv
`timescale 1ns/1ps
module sp_latch_ctl
   import synth_prog_pkg::*;
#(
   parameter int DATA_W = 19
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [DATA_W+CODE_W-1:0] word,
   input  logic                     chip_en,
   output logic [DATA_W-1:0]        r_q,
   output logic [DATA_W-1:0]        n_q,
   output logic [DATA_W-1:0]        f_q,
   output logic                     pulse_q,
   output logic                     pd_q,
   output logic                     hold
);
   initial assert (DATA_W > FB_PD_SYNC) else $error("sp_latch_ctl: payload too narrow");

   dest_e             code;
   logic [DATA_W-1:0] data;
   logic              is_ref, is_main, is_func, is_init;
   logic              armed, fire, pd_sel, pd_next;

   assign code    = dest_e'(word[CODE_W-1:0]);
   assign data    = word[DATA_W+CODE_W-1:CODE_W];
   assign is_ref  = load && code == DST_REF;
   assign is_main = load && code == DST_MAIN;
   assign is_func = load && code == DST_FUNC;
   assign is_init = load && code == DST_INIT;
   assign fire    = is_init || (is_main && armed);
   // an initialization load decides on the word it is writing
   assign pd_sel  = is_init ? (data[FB_PD_EN] & data[FB_PD_SYNC])
                            : (f_q[FB_PD_EN]  & f_q[FB_PD_SYNC]);
   assign pd_next = fire && chip_en && pd_sel;
   assign hold    = pulse_q | f_q[FB_CRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q     <= '0;
         n_q     <= '0;
         f_q     <= '0;
         armed   <= 1'b0;
         pulse_q <= 1'b0;
         pd_q    <= 1'b0;
      end else begin
         if (is_ref)             r_q <= data;
         if (is_main)            n_q <= data;
         if (is_func || is_init) f_q <= data;
         if (is_init)            armed <= 1'b1;
         else if (is_main)       armed <= 1'b0;
         pulse_q <= fire;
         pd_q    <= pd_next;
      end
   end

   // R5: one-cycle strobe
   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R5: initialization load strobes and arms
   p_init_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_init |=> pulse_q && armed);
   // R4: function load does not strobe
   p_func_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_func |=> !pulse_q);
   // R6: unarmed main load gives no strobe
   p_main_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_main && !armed) |=> !pulse_q);
   // R6: armed main load strobes and disarms
   p_main_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_main && armed) |=> pulse_q && !armed);
   // R7: powerdown only with a strobe
   p_pd_needs_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |-> pulse_q);
   // R9: strobe always tri-states
   p_hold_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> hold);
   // R10: words change only on a load
   p_words_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(r_q) && $stable(n_q) && $stable(f_q));
endmodule

// File: rtl/synth_prog_if.sv
`timescale 1ns/1ps
module synth_prog_if
   import synth_prog_pkg::*;
#(
   parameter int WORD_W      = WORD_W_DEF,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   input  logic              chip_en,
   output logic [WORD_W-3:0] r_word,
   output logic [WORD_W-3:0] n_word,
   output logic [WORD_W-3:0] f_word,
   output logic              ctr_reset,
   output logic              sync_pd,
   output logic              hold_tristate
);
   localparam int DATA_W = WORD_W - CODE_W;

   initial assert (DATA_W > FB_PD_SYNC && SYNC_STAGES >= 0)
      else $error("synth_prog_if: bad parameters");

   logic [2:0]        pins_s;
   logic [WORD_W-1:0] sr_word;
   logic              le_rise;

   sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_le, ser_data, ser_clk}),
      .q     (pins_s)
   );

   sp_shift #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (pins_s[0]),
      .sdata   (pins_s[1]),
      .le      (pins_s[2]),
      .word    (sr_word),
      .le_rise (le_rise)
   );

   sp_latch_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (le_rise),
      .word    (sr_word),
      .chip_en (chip_en),
      .r_q     (r_word),
      .n_q     (n_word),
      .f_q     (f_word),
      .pulse_q (ctr_reset),
      .pd_q    (sync_pd),
      .hold    (hold_tristate)
   );

   // R8: level reset bit keeps counters held
   p_crst_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      f_word[FB_CRST] |-> hold_tristate);
   // R7: no powerdown while disabled
   p_pd_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pd |-> $past(chip_en));
endmodule

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb;
   localparam int WORD_W = 21;
   localparam int DW     = WORD_W - 2;
   localparam int SYNC   = 2;
   localparam int LAT    = SYNC + 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b0;
   logic [DW-1:0] r_word, n_word, f_word;
   logic ctr_reset, sync_pd, hold_tristate;

   synth_prog_if #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .chip_en(chip_en), .r_word(r_word), .n_word(n_word),
      .f_word(f_word), .ctr_reset(ctr_reset), .sync_pd(sync_pd),
      .hold_tristate(hold_tristate)
   );

   typedef struct {
      int            due;
      logic [DW-1:0] r, n, f;
      logic          pulse, pd;
      string         req;
   } item_t;

   item_t q[$];
   int cyc = 0, checks = 0, errors = 0;
   logic [DW-1:0] c_r = '0, c_n = '0, c_f = '0;
   logic [DW-1:0] m_r = '0, m_n = '0, m_f = '0;
   logic m_armed = 1'b0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // monitor / scoreboard
   always begin
      logic  e_pulse, e_pd;
      string tag;
      @(posedge clk);
      #1;
      cyc++;
      if (!rst_n) begin
         c_r = '0; c_n = '0; c_f = '0;
         q.delete();
      end else begin
         e_pulse = 1'b0; e_pd = 1'b0; tag = "R10";
         if (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            c_r = it.r; c_n = it.n; c_f = it.f;
            e_pulse = it.pulse; e_pd = it.pd; tag = it.req;
         end
         chk(tag, "r_word", 32'(r_word), 32'(c_r));
         chk(tag, "n_word", 32'(n_word), 32'(c_n));
         chk(tag, "f_word", 32'(f_word), 32'(c_f));
         chk(tag, "ctr_reset", 32'(ctr_reset), 32'(e_pulse));
         chk(tag, "sync_pd", 32'(sync_pd), 32'(e_pd));
         chk(tag, "hold_tristate", 32'(hold_tristate), 32'(e_pulse | c_f[0]));
      end
   end

   // driver: shift a word, strobe, push expectation
   task automatic load(input logic [1:0] code, input logic [DW-1:0] d, input string req);
      logic [WORD_W-1:0] w;
      logic pulse, pd;
      item_t it;
      w = {d, code};
      for (int i = WORD_W - 1; i >= 0; i--) begin
         @(negedge clk); ser_data = w[i];
         repeat (4) @(negedge clk); ser_clk = 1'b1;
         repeat (4) @(negedge clk); ser_clk = 1'b0;
      end
      pulse = (code == 2'b11) || (code == 2'b10 && m_armed);
      case (code)
         2'b00: m_r = d;
         2'b10: begin m_n = d; m_armed = 1'b0; end
         2'b01: m_f = d;
         default: begin m_f = d; m_armed = 1'b1; end
      endcase
      pd = pulse && chip_en && m_f[1] && m_f[17];
      @(negedge clk);
      ser_le = 1'b1;
      it.due = cyc + LAT; it.r = m_r; it.n = m_n; it.f = m_f;
      it.pulse = pulse; it.pd = pd; it.req = req;
      q.push_back(it);
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_r = '0; m_n = '0; m_f = '0; m_armed = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   localparam logic [DW-1:0] PD_BITS = DW'((1 << 17) | (1 << 1));

   initial begin
      do_reset();
      // R11: reset state
      chk("R11", "r_word reset", 32'(r_word), 0);
      chk("R11", "n_word reset", 32'(n_word), 0);
      chk("R11", "f_word reset", 32'(f_word), 0);
      chk("R11", "ctr_reset reset", 32'(ctr_reset), 0);

      load(2'b00, DW'(50), "R2");
      load(2'b00, 19'h5A5A5, "R1");
      load(2'b10, DW'(4750), "R3");
      load(2'b10, 19'h40001, "R1");
      load(2'b01, 19'h00001, "R4 R8");
      load(2'b01, 19'h00000, "R4");
      chip_en = 1'b1;
      load(2'b11, PD_BITS, "R5 R7 R12");
      load(2'b10, DW'(1234), "R6 R7");
      load(2'b10, DW'(1235), "R6");
      chip_en = 1'b0;
      load(2'b11, PD_BITS, "R7 R5");
      load(2'b00, DW'(77), "R10");
      repeat (5) @(negedge clk); chip_en = 1'b1;
      repeat (5) @(negedge clk); chip_en = 1'b0;
      repeat (5) @(negedge clk); chip_en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10", "r_word kept", 32'(r_word), 77);
      chk("R10", "n_word kept", 32'(n_word), 1235);
      load(2'b01, PD_BITS | 19'h1, "R8");
      load(2'b11, PD_BITS | 19'h1, "R9 R7");
      load(2'b10, DW'(9), "R6 R9");
      do_reset();
      chk("R11", "f_word after reset", 32'(f_word), 0);
      load(2'b10, DW'(321), "R11");
      repeat (10) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule